// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block turns a single-cycle fault request from a processor pipeline into the architectural side effects of taking an exception. It classifies the fault into a 5-bit cause code, forms the handler address from a selectable base and a fault-dependent offset, and records the fault details in a small set of system-control registers. It then hands the pipeline a one-cycle redirect strobe together with the handler address.

The request carries a fault kind, a load/store direction, the faulting virtual address, an address-space identifier, a virtual page number and a coprocessor number. Software-visible controls are changed through a simple write port: boot-vector select, exception level, vectored-interrupt enable and the programmable exception base. Every modelled register can be read back through a combinational read port. While a redirect is being presented, the block drops its ready output, so at most one fault is taken per redirect.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset: status reads 0x00400000 (boot-vector bit 22 set, exception-level bit 1 clear); cause, bad-address, TLB-high and TLB-context read 0; exception base reads 0x80000000; redirect is low and req_ready is high.
- R2: The cause code in cause bits 6:2 is set by req_kind as follows. 0 interrupt→0, 5 syscall→8, 6 breakpoint→9, 7 reserved instruction→10, 8 coprocessor unusable→11, 9 overflow→12, 10 trap→13, 11 machine check→24, 12 thread→25, 13 instruction bus error→6, 14 data bus error→7, 15 watch→23.
- R3: For kinds 1 (TLB refill), 2 (TLB invalid) and 4 (address error), req_store selects the store code (3 for TLB, 5 for address error) over the load code (2 for TLB, 4 for address error). Kind 3 (TLB modified) always gives code 1.
- R4: The handler base is the exception-base register when the boot-vector bit is set, and 0xBFC00200 when it is clear.
- R5: An interrupt uses offset 0x200 when cause bit 23 (vectored-interrupt enable) is set, and 0x000 otherwise.
- R6: A TLB refill uses offset 0x180 when the exception-level bit is already set, and 0x000 otherwise. Every other non-interrupt kind uses 0x180.
- R7: Kinds 1 to 4 load req_vaddr into the bad-address register. All other kinds leave it unchanged.
- R8: Kinds 1 to 3 load TLB-high with the ASID in bits 7:0, VPN bits 1:0 in bits 12:11 and VPN bits 20:2 in bits 31:13. They load TLB-context bits 22:4 with VPN bits 20:2. Other kinds leave both registers unchanged.
- R9: Kind 8 writes req_cop into cause bits 29:28. Other kinds leave that field unchanged.
- R10: An accepted request (req_valid and req_ready at a rising edge) sets the exception-level bit and the cause code at that edge. redirect is high for exactly the following cycle, and redirect_pc equals base plus offset computed from the register state before the edge.
- R11: req_ready is low while redirect is high. A request presented then is ignored: it changes no register and causes no further redirect.
- R12: The write port selects with wr_sel as follows. 0 writes status bits 22 and 1. 1 writes only cause bit 23; all other cause bits keep their values. 2 writes the whole exception base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Fault request strobe |
| req_ready | output | 1 | Block can take a fault this cycle |
| req_kind | input | 4 | Encoded fault kind |
| req_store | input | 1 | Faulting access was a store |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Address-space identifier of the access |
| req_vpn | input | 21 | Virtual page number of the access |
| req_cop | input | 2 | Coprocessor number for coprocessor-unusable faults |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status, 1 cause, 2 exception base |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read select: 0 status, 1 cause, 2 base, 3 bad address, 4 TLB-high, 5 TLB-context |
| rd_data | output | 32 | Selected register value |
| redirect | output | 1 | One-cycle handler redirect strobe |
| redirect_pc | output | 32 | Handler address |

## Verification
The assertions assume that the request fields are known values whenever req_valid is high. They also assume that all sixteen kind encodings are legal, so no illegal-kind handling is assumed. The assertions on held-off requests rely on the requester keeping req_valid asserted across a redirect cycle without any special sequencing. The stimulus drives every input only at the falling clock edge. It never places a register write in the same cycle as an accepted fault, and it deliberately holds a changed request over a redirect cycle to exercise the hold-off path.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN = 32;

  typedef enum logic [3:0] {
    FK_INTR       = 4'd0,
    FK_TLB_REFILL = 4'd1,
    FK_TLB_INVAL  = 4'd2,
    FK_TLB_MOD    = 4'd3,
    FK_ADDR_ERR   = 4'd4,
    FK_SYSCALL    = 4'd5,
    FK_BREAK      = 4'd6,
    FK_RESV_INSN  = 4'd7,
    FK_COP_UNUSE  = 4'd8,
    FK_OVFL       = 4'd9,
    FK_TRAP       = 4'd10,
    FK_MCHECK     = 4'd11,
    FK_THREAD     = 4'd12,
    FK_IBUS       = 4'd13,
    FK_DBUS       = 4'd14,
    FK_WATCH      = 4'd15
  } fault_kind_e;

  localparam logic [XLEN-1:0] ALT_BASE   = 32'hBFC0_0200;
  localparam logic [XLEN-1:0] EBASE_RST  = 32'h8000_0000;
  localparam logic [XLEN-1:0] OFF_ZERO   = 32'h0000_0000;
  localparam logic [XLEN-1:0] OFF_GEN    = 32'h0000_0180;
  localparam logic [XLEN-1:0] OFF_VINT   = 32'h0000_0200;

  localparam int STAT_BEV_BIT  = 22;
  localparam int STAT_EXL_BIT  = 1;
  localparam int CAUSE_IV_BIT  = 23;
  localparam int CAUSE_CE_LSB  = 28;
  localparam int CAUSE_CODE_LSB = 2;
  localparam int HI_VPN2_LSB   = 13;
  localparam int HI_VPN2X_LSB  = 11;
  localparam int CTX_VPN2_LSB  = 4;

  typedef struct packed {
    logic [4:0]      code;
    logic [XLEN-1:0] offset;
    logic            addr_kind;
    logic            tlb_kind;
    logic            cop_kind;
  } fault_info_t;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
(
  input  logic [3:0]  kind,
  input  logic        store,
  input  logic        exl,
  input  logic        iv,
  output fault_info_t info
);

  always_comb begin
    info = '{code: 5'd0, offset: OFF_GEN, addr_kind: 1'b0,
             tlb_kind: 1'b0, cop_kind: 1'b0};
    unique case (fault_kind_e'(kind))
      FK_INTR: begin
        info.code   = 5'd0;
        info.offset = iv ? OFF_VINT : OFF_ZERO;
      end
      FK_TLB_REFILL: begin
        info.code      = store ? 5'd3 : 5'd2;
        info.offset    = exl ? OFF_GEN : OFF_ZERO;
        info.addr_kind = 1'b1;
        info.tlb_kind  = 1'b1;
      end
      FK_TLB_INVAL: begin
        info.code      = store ? 5'd3 : 5'd2;
        info.addr_kind = 1'b1;
        info.tlb_kind  = 1'b1;
      end
      FK_TLB_MOD: begin
        info.code      = 5'd1;
        info.addr_kind = 1'b1;
        info.tlb_kind  = 1'b1;
      end
      FK_ADDR_ERR: begin
        info.code      = store ? 5'd5 : 5'd4;
        info.addr_kind = 1'b1;
      end
      FK_SYSCALL:   info.code = 5'd8;
      FK_BREAK:     info.code = 5'd9;
      FK_RESV_INSN: info.code = 5'd10;
      FK_COP_UNUSE: begin
        info.code     = 5'd11;
        info.cop_kind = 1'b1;
      end
      FK_OVFL:      info.code = 5'd12;
      FK_TRAP:      info.code = 5'd13;
      FK_MCHECK:    info.code = 5'd24;
      FK_THREAD:    info.code = 5'd25;
      FK_IBUS:      info.code = 5'd6;
      FK_DBUS:      info.code = 5'd7;
      FK_WATCH:     info.code = 5'd23;
      default:      info.code = 5'd0;
    endcase
  end

  // R3: a modify fault never takes a direction-dependent code
  always_comb begin
    if (kind == FK_TLB_MOD) begin
      p_tlbmod_code_r3: assert (info.code == 5'd1 && info.tlb_kind);
    end
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
(
  input  logic            bev,
  input  logic [XLEN-1:0] ebase,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] vector
);

  logic [XLEN-1:0] base;

  always_comb begin
    base   = bev ? ebase : ALT_BASE;
    vector = base + offset;
  end

endmodule

// File: rtl/exc_sysregs.sv
module exc_sysregs
  import exc_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int VPN_W  = 21,
  parameter int CP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_we,
  input  fault_info_t       info,
  input  logic [XLEN-1:0]   vaddr,
  input  logic [ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [CP_W-1:0]   cop,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [2:0]        rd_sel,
  output logic              bev,
  output logic              exl,
  output logic              iv,
  output logic [XLEN-1:0]   ebase,
  output logic [XLEN-1:0]   rd_data
);

  localparam int VPN2_W = VPN_W - 2;

  logic              bev_q, bev_d;
  logic              exl_q, exl_d;
  logic              iv_q, iv_d;
  logic [CP_W-1:0]   ce_q, ce_d;
  logic [4:0]        code_q, code_d;
  logic [XLEN-1:0]   ebase_q, ebase_d;
  logic [XLEN-1:0]   bad_q, bad_d;
  logic [ASID_W-1:0] hi_asid_q, hi_asid_d;
  logic [VPN2_W-1:0] hi_vpn2_q, hi_vpn2_d;
  logic [1:0]        hi_vpn2x_q, hi_vpn2x_d;
  logic [VPN2_W-1:0] ctx_vpn2_q, ctx_vpn2_d;

  // next state: software write first, fault side effects override
  always_comb begin
    bev_d      = bev_q;
    exl_d      = exl_q;
    iv_d       = iv_q;
    ce_d       = ce_q;
    code_d     = code_q;
    ebase_d    = ebase_q;
    bad_d      = bad_q;
    hi_asid_d  = hi_asid_q;
    hi_vpn2_d  = hi_vpn2_q;
    hi_vpn2x_d = hi_vpn2x_q;
    ctx_vpn2_d = ctx_vpn2_q;
    if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          bev_d = wr_data[STAT_BEV_BIT];
          exl_d = wr_data[STAT_EXL_BIT];
        end
        2'd1:    iv_d    = wr_data[CAUSE_IV_BIT];
        2'd2:    ebase_d = wr_data;
        default: ;
      endcase
    end
    if (fault_we) begin
      exl_d  = 1'b1;
      code_d = info.code;
      if (info.cop_kind)  ce_d  = cop;
      if (info.addr_kind) bad_d = vaddr;
      if (info.tlb_kind) begin
        hi_asid_d  = asid;
        hi_vpn2_d  = vpn[VPN_W-1:2];
        hi_vpn2x_d = vpn[1:0];
        ctx_vpn2_d = vpn[VPN_W-1:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bev_q      <= 1'b1;
      exl_q      <= 1'b0;
      iv_q       <= 1'b0;
      ce_q       <= '0;
      code_q     <= '0;
      ebase_q    <= EBASE_RST;
      bad_q      <= '0;
      hi_asid_q  <= '0;
      hi_vpn2_q  <= '0;
      hi_vpn2x_q <= '0;
      ctx_vpn2_q <= '0;
    end else begin
      bev_q      <= bev_d;
      exl_q      <= exl_d;
      iv_q       <= iv_d;
      ce_q       <= ce_d;
      code_q     <= code_d;
      ebase_q    <= ebase_d;
      bad_q      <= bad_d;
      hi_asid_q  <= hi_asid_d;
      hi_vpn2_q  <= hi_vpn2_d;
      hi_vpn2x_q <= hi_vpn2x_d;
      ctx_vpn2_q <= ctx_vpn2_d;
    end
  end

  logic [XLEN-1:0] status_w, cause_w, hi_w, ctx_w;

  always_comb begin
    status_w = '0;
    status_w[STAT_BEV_BIT] = bev_q;
    status_w[STAT_EXL_BIT] = exl_q;
    cause_w = '0;
    cause_w[CAUSE_IV_BIT] = iv_q;
    cause_w[CAUSE_CE_LSB +: CP_W] = ce_q;
    cause_w[CAUSE_CODE_LSB +: 5] = code_q;
    hi_w = '0;
    hi_w[0 +: ASID_W] = hi_asid_q;
    hi_w[HI_VPN2X_LSB +: 2] = hi_vpn2x_q;
    hi_w[HI_VPN2_LSB +: VPN2_W] = hi_vpn2_q;
    ctx_w = '0;
    ctx_w[CTX_VPN2_LSB +: VPN2_W] = ctx_vpn2_q;
    case (rd_sel)
      3'd0:    rd_data = status_w;
      3'd1:    rd_data = cause_w;
      3'd2:    rd_data = ebase_q;
      3'd3:    rd_data = bad_q;
      3'd4:    rd_data = hi_w;
      3'd5:    rd_data = ctx_w;
      default: rd_data = '0;
    endcase
  end

  assign bev   = bev_q;
  assign exl   = exl_q;
  assign iv    = iv_q;
  assign ebase = ebase_q;

  // R7: address-type faults capture the faulting address
  p_badaddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we && info.addr_kind |=> bad_q == $past(vaddr));

  // R8: low VPN bits land in the TLB-high extension field
  p_vpn2x_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we && info.tlb_kind |=> hi_vpn2x_q == $past(vpn[1:0]));

  // R9: only coprocessor-unusable faults touch the coprocessor field
  p_ce_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we && !info.cop_kind |=> $stable(ce_q));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int VPN_W  = 21,
  parameter int CP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_kind,
  input  logic              req_store,
  input  logic [XLEN-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [CP_W-1:0]   req_cop,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [2:0]        rd_sel,
  output logic [XLEN-1:0]   rd_data,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic            bev, exl, iv;
  logic [XLEN-1:0] ebase;
  logic [XLEN-1:0] vector;
  fault_info_t     info;
  logic            accept;
  logic            redirect_q, redirect_d;
  logic [XLEN-1:0] pc_q, pc_d;

  assign req_ready = rst_int_n & ~redirect_q;
  assign accept    = req_valid & req_ready;

  exc_classify u_classify (
    .kind  (req_kind),
    .store (req_store),
    .exl   (exl),
    .iv    (iv),
    .info  (info)
  );

  exc_vector u_vector (
    .bev    (bev),
    .ebase  (ebase),
    .offset (info.offset),
    .vector (vector)
  );

  exc_sysregs #(
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W),
    .CP_W   (CP_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fault_we (accept),
    .info     (info),
    .vaddr    (req_vaddr),
    .asid     (req_asid),
    .vpn      (req_vpn),
    .cop      (req_cop),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .bev      (bev),
    .exl      (exl),
    .iv       (iv),
    .ebase    (ebase),
    .rd_data  (rd_data)
  );

  always_comb begin
    redirect_d = accept;
    pc_d       = pc_q;
    if (accept) pc_d = vector;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      redirect_q <= 1'b0;
      pc_q       <= '0;
    end else begin
      redirect_q <= redirect_d;
      pc_q       <= pc_d;
    end
  end

  assign redirect    = redirect_q;
  assign redirect_pc = pc_q;

  // R10: redirect never lasts beyond one cycle
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect_q |=> !redirect_q);

  // R10: taking a fault raises the exception level
  p_exl_set_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> exl);

  // R11: a request held across a redirect is not taken
  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect_q && req_valid |=> !redirect_q);

endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_kind;
  logic        req_store;
  logic [31:0] req_vaddr;
  logic [7:0]  req_asid;
  logic [20:0] req_vpn;
  logic [1:0]  req_cop;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic        redirect;
  logic [31:0] redirect_pc;

  always #(CLK_P/2) clk = ~clk;

  exc_entry_unit u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_kind (req_kind), .req_store (req_store),
    .req_vaddr (req_vaddr), .req_asid (req_asid),
    .req_vpn (req_vpn), .req_cop (req_cop),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_data (rd_data),
    .redirect (redirect), .redirect_pc (redirect_pc)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] exp_q[$];

  // reference state, built from the requirements
  logic        m_bev, m_exl, m_iv;
  logic [1:0]  m_ce;
  logic [4:0]  m_code;
  logic [31:0] m_ebase, m_bad, m_hi, m_ctx;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] m_code_of(logic [3:0] k, logic st);
    case (k)
      4'd0: return 5'd0;
      4'd1, 4'd2: return st ? 5'd3 : 5'd2;
      4'd3: return 5'd1;
      4'd4: return st ? 5'd5 : 5'd4;
      4'd5: return 5'd8;
      4'd6: return 5'd9;
      4'd7: return 5'd10;
      4'd8: return 5'd11;
      4'd9: return 5'd12;
      4'd10: return 5'd13;
      4'd11: return 5'd24;
      4'd12: return 5'd25;
      4'd13: return 5'd6;
      4'd14: return 5'd7;
      default: return 5'd23;
    endcase
  endfunction

  task automatic read_reg(input logic [2:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] d;
    read_reg(3'd0, d); check({tag, " status"}, d, (32'(m_bev) << 22) | (32'(m_exl) << 1));
    read_reg(3'd1, d); check({tag, " cause"}, d,
      (32'(m_iv) << 23) | (32'(m_ce) << 28) | (32'(m_code) << 2));
    read_reg(3'd2, d); check({tag, " base"}, d, m_ebase);
    read_reg(3'd3, d); check({tag, " badaddr"}, d, m_bad);
    read_reg(3'd4, d); check({tag, " tlbhi"}, d, m_hi);
    read_reg(3'd5, d); check({tag, " tlbctx"}, d, m_ctx);
  endtask

  task automatic sw_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: begin m_bev = d[22]; m_exl = d[1]; end
      2'd1: m_iv = d[23];
      2'd2: m_ebase = d;
      default: ;
    endcase
  endtask

  // driver: compute expectation, push it, present the request
  task automatic fire(logic [3:0] k, logic st, logic [31:0] va,
                      logic [7:0] asid, logic [20:0] vpn, logic [1:0] cop,
                      bit hold_other);
    logic [31:0] base, off;
    base = m_bev ? m_ebase : 32'hBFC0_0200;
    if (k == 4'd0)      off = m_iv ? 32'h200 : 32'h0;
    else if (k == 4'd1) off = m_exl ? 32'h180 : 32'h0;
    else                off = 32'h180;
    exp_q.push_back(base + off);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_store = st; req_vaddr = va;
    req_asid = asid; req_vpn = vpn; req_cop = cop;
    @(negedge clk);
    if (hold_other) begin
      req_kind = 4'd8; req_store = 1'b1; req_vaddr = ~va;
      req_vpn = ~vpn; req_cop = ~cop;
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    m_exl  = 1'b1;
    m_code = m_code_of(k, st);
    if (k == 4'd8) m_ce = cop;
    if (k >= 4'd1 && k <= 4'd4) m_bad = va;
    if (k >= 4'd1 && k <= 4'd3) begin
      m_hi  = (32'(vpn >> 2) << 13) | (32'(vpn[1:0]) << 11) | 32'(asid);
      m_ctx = 32'(vpn >> 2) << 4;
    end
  endtask

  // monitor: compare each redirect against the scoreboard
  bit prev_redir = 0;
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1) begin
      if (redirect === 1'b1) begin
        check("R11 ready low during redirect", 32'(req_ready), 32'd0);
        check("R10 single-cycle redirect", 32'(prev_redir), 32'd0);
        if (exp_q.size() == 0) begin
          check("R10 unexpected redirect", 32'd1, 32'd0);
        end else begin
          check("R10 R4 R5 R6 redirect_pc", redirect_pc, exp_q.pop_front());
        end
      end
      prev_redir = (redirect === 1'b1);
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_store = 1'b0;
    req_vaddr = '0; req_asid = '0; req_vpn = '0; req_cop = '0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    m_bev = 1'b1; m_exl = 1'b0; m_iv = 1'b0; m_ce = '0; m_code = '0;
    m_ebase = 32'h8000_0000; m_bad = '0; m_hi = '0; m_ctx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_regs("R1");
    check("R1 redirect", 32'(redirect), 32'd0);
    check("R1 ready", 32'(req_ready), 32'd1);

    // R12: cause write changes only the vectored-interrupt bit
    sw_write(2'd1, 32'hFFFF_FFFF);
    check_regs("R12 cause write");
    sw_write(2'd0, 32'h0);
    sw_write(2'd2, 32'h9000_1000);
    check_regs("R12 status/base write");

    // R4 clear boot bit, R2 syscall; R5 vectored interrupt
    fire(4'd5, 1'b0, 32'h1234_5678, 8'h11, 21'h1, 2'd0, 0);
    check_regs("R2 R4 syscall");
    fire(4'd0, 1'b0, 32'h0, 8'h0, 21'h0, 2'd0, 0);
    check_regs("R5 interrupt iv=1");
    sw_write(2'd1, 32'h0);
    fire(4'd0, 1'b0, 32'h0, 8'h0, 21'h0, 2'd0, 0);
    check_regs("R5 interrupt iv=0");

    // R6: refill with level set, then cleared
    fire(4'd1, 1'b1, 32'hDEAD_BEE0, 8'hA5, 21'h1A_BCDE, 2'd0, 0);
    check_regs("R6 R3 R8 refill store exl=1");
    sw_write(2'd0, 32'h0);
    fire(4'd1, 1'b0, 32'h0040_2000, 8'h3C, 21'h0_0403, 2'd0, 0);
    check_regs("R6 R3 R8 refill load exl=0");

    // R4: boot bit selects programmable base
    sw_write(2'd0, 32'h0040_0000);
    fire(4'd2, 1'b0, 32'hCAFE_0004, 8'h7F, 21'h15_5555, 2'd0, 0);
    check_regs("R4 R3 R8 invalid load");
    fire(4'd3, 1'b1, 32'hCAFE_1008, 8'h01, 21'h0A_AAAA, 2'd0, 0);
    check_regs("R3 R8 modified store");
    fire(4'd4, 1'b0, 32'h0000_0003, 8'hEE, 21'h1F_FFFF, 2'd0, 0);
    check_regs("R3 R7 addr load, tlb unchanged");
    fire(4'd4, 1'b1, 32'h0000_0005, 8'hEE, 21'h1F_FFFF, 2'd0, 0);
    check_regs("R3 R7 addr store");

    // R9: coprocessor field written, then preserved
    fire(4'd8, 1'b0, 32'h5555_0000, 8'h0, 21'h0, 2'd3, 0);
    check_regs("R9 cop unusable");
    fire(4'd6, 1'b0, 32'h7777_0000, 8'h9, 21'h9, 2'd1, 0);
    check_regs("R9 R7 breakpoint leaves ce/badaddr");

    // R2: remaining kinds
    for (int k = 7; k < 16; k++) begin
      if (k != 8) begin
        fire(4'(k), 1'b1, 32'h0BAD_0000 + 32'(k), 8'(k), 21'(k), 2'd2, 0);
        check_regs("R2 plain kind");
      end
    end

    // R11: request changed and held across the redirect cycle
    fire(4'd10, 1'b0, 32'h1111_2222, 8'h2, 21'h3, 2'd0, 1);
    check_regs("R11 held request ignored");
    repeat (3) @(negedge clk);
    check("R10 no missing redirect", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule